// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar date. It advances by one second on each cycle in which a one-second enable is high. That enable comes from an outside prescaler that divides a 32.768 kHz reference down to 1 Hz. Seconds, minutes, hours, day of month, weekday, month and a two-digit year are each held as a packed BCD byte, with the tens digit in the upper nibble. Each field carries into the next when it reaches its limit. The length of each month is taken into account. The year field stands for 2000 to 2099, and a year divisible by four, 00 included, gets a 29th of February.

A host register port works alongside the counter and never holds it up. A read of the seconds address returns the live seconds. On the same edge it freezes every other field into a snapshot, so the later reads of minutes, hours and the date all belong to that same second, even if a carry happens in between. A write replaces one field at the clock edge. A tick arriving on that same edge still advances every other field. A write to the seconds field also sends a one-cycle restart request to the prescaler.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read 00:00:00, day of month 01, month 01, year 00 and weekday 0; host_rdata and presc_clr are 0.
- R2: Each field is packed BCD, tens in bits 7:4 and units in bits 3:0. Seconds advance on a tick and wrap from 59 to 00, carrying into minutes. Minutes wrap the same way and carry into hours. With no tick and no write, no field changes.
- R3: Hours count 00 to 23 and wrap to 00, carrying into the day of month and the weekday.
- R4: April, June, September and November (month codes 04, 06, 09 and 11) roll over after day 30. February rolls over after day 28 in a non-leap year. All other months roll over after day 31. The day then restarts at 01 and the month advances.
- R5: The year code 00 to 99 stands for 2000 to 2099. A year divisible by four, 00 included, gives February 29 days. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: The weekday counts 0 to 6. It advances whenever the day of month advances and wraps from 6 to 0.
- R7: The field addresses are 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 year and 6 weekday. A write with host_we stores host_wdata in the addressed field at that edge, and this takes precedence over a tick update of that field. A write to address 7 changes nothing.
- R8: A read with host_re at address 0 returns the live seconds on host_rdata one cycle later. On the same edge it captures all the other fields. A read at addresses 1 to 6 returns the captured value one cycle later. A read at address 7 returns 00.
- R9: A write to address 0 raises presc_clr for exactly the following cycle.
- R10: A tick that coincides with a host read, or with a write to a field other than seconds, is never lost: all the fields that are not written advance as on a plain tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second advance enable |
| host_addr | input | 3 | Field address for host access |
| host_wdata | input | 8 | BCD write value |
| host_we | input | 1 | Write strobe |
| host_re | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, one cycle after host_re |
| presc_clr | output | 1 | Prescaler restart request |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within century, BCD |
| wday_o | output | 8 | Weekday 0 to 6 |

## Verification
Every field is a register that drives an output directly, so a wrong count or a lost carry shows at the ports on the clock after the faulty tick. A wrong month length or leap rule stays hidden until the day-of-month field reaches its limit, and then shows as a wrong date on the very next carry. For that reason the bench loads the counter just before each month end and year end it cares about. A corrupt snapshot stays hidden until a host read at a nonzero address, and then appears on host_rdata one cycle later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DW         = 8;
    localparam int ADDR_W     = 3;
    localparam int NSLOT      = 1 << ADDR_W;
    localparam int NFIELD     = 7;
    localparam int IDX_SEC    = 0;
    localparam int IDX_MIN    = 1;
    localparam int IDX_HOUR   = 2;
    localparam int IDX_DATE   = 3;
    localparam int IDX_MONTH  = 4;
    localparam int IDX_YEAR   = 5;
    localparam int IDX_WDAY   = 6;

    typedef logic [DW-1:0] bcd_t;

    typedef struct packed {
        logic [NSLOT-1:0][DW-1:0] snap;
        bcd_t                     rdata;
        logic                     presc_clr;
    } host_st_t;

    // two-digit BCD increment; caller handles the wrap limit
    function automatic bcd_t bcd_inc(bcd_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(bcd_t v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic bcd_t field_floor(int i);
        return (i == IDX_DATE || i == IDX_MONTH) ? 8'h01 : 8'h00;
    endfunction

    function automatic bcd_t field_ceil(int i);
        case (i)
            IDX_SEC, IDX_MIN: return 8'h59;
            IDX_HOUR:         return 8'h23;
            IDX_DATE:         return 8'h31;
            IDX_MONTH:        return 8'h12;
            IDX_YEAR:         return 8'h99;
            default:          return 8'h06;
        endcase
    endfunction

    // which field's carry advances field i (i > 0)
    function automatic int field_parent(int i);
        return (i == IDX_WDAY) ? IDX_HOUR : i - 1;
    endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
    import rtc_pkg::*;
#(
    parameter bcd_t FLOOR = 8'h00,
    parameter bcd_t CEIL  = 8'h59,
    parameter bit   DYN   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    input  bcd_t dyn_ceil_i,
    input  logic wr_en_i,
    input  bcd_t wr_val_i,
    output bcd_t val_o,
    output logic carry_o
);
    bcd_t val_d, val_q;
    bcd_t ceil_w;
    logic at_top;

    always_comb begin
        ceil_w  = DYN ? dyn_ceil_i : CEIL;
        at_top  = (val_q >= ceil_w);
        carry_o = adv_i && at_top;
        val_d   = val_q;
        if (adv_i) begin
            val_d = at_top ? FLOOR : bcd_inc(val_q);
        end
        if (wr_en_i) begin
            val_d = wr_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= FLOOR;
        else     val_q <= val_d;
    end

    assign val_o = val_q;
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  bcd_t month_i,
    input  bcd_t year_i,
    output bcd_t last_day_o
);
    logic [6:0] mon_bin;
    logic [6:0] yr_bin;
    logic       leap;

    always_comb begin
        mon_bin = bcd_to_bin(month_i);
        yr_bin  = bcd_to_bin(year_i);
        leap    = (yr_bin[1:0] == 2'b00);
        case (mon_bin)
            7'd4, 7'd6, 7'd9, 7'd11: last_day_o = 8'h30;
            7'd2:                    last_day_o = leap ? 8'h29 : 8'h28;
            default:                 last_day_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
    import rtc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      re_i,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [NFIELD-1:0][DW-1:0] fields_i,
    output bcd_t                      rdata_o,
    output logic                      presc_clr_o
);
    localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(IDX_SEC);
    localparam int                PAD_W    = (NSLOT - NFIELD) * DW;

    host_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.presc_clr = we_i && (addr_i == SEC_ADDR);
        if (re_i) begin
            if (addr_i == SEC_ADDR) begin
                st_d.snap  = {{PAD_W{1'b0}}, fields_i};
                st_d.rdata = fields_i[IDX_SEC];
            end else begin
                st_d.rdata = st_q.snap[addr_i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata_o     = st_q.rdata;
    assign presc_clr_o = st_q.presc_clr;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic              host_we,
    input  logic              host_re,
    output logic [DW-1:0]     host_rdata,
    output logic              presc_clr,
    output logic [DW-1:0]     sec_o,
    output logic [DW-1:0]     min_o,
    output logic [DW-1:0]     hour_o,
    output logic [DW-1:0]     date_o,
    output logic [DW-1:0]     month_o,
    output logic [DW-1:0]     year_o,
    output logic [DW-1:0]     wday_o
);
    logic [NFIELD-1:0][DW-1:0] vals;
    logic [NFIELD-1:0]         adv;
    logic [NFIELD-1:0]         carry;
    logic [NFIELD-1:0]         wr_en;
    bcd_t                      last_day;
    logic                      unused_carry;

    rtc_month_len u_mlen (
        .month_i    (vals[IDX_MONTH]),
        .year_i     (vals[IDX_YEAR]),
        .last_day_o (last_day)
    );

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        if (i == 0) begin : g_src
            assign adv[i] = tick_1hz;
        end else begin : g_src
            assign adv[i] = carry[field_parent(i)];
        end

        assign wr_en[i] = host_we && (host_addr == ADDR_W'(i));

        rtc_bcd_field #(
            .FLOOR (field_floor(i)),
            .CEIL  (field_ceil(i)),
            .DYN   (i == IDX_DATE)
        ) u_f (
            .clk        (clk),
            .rst        (rst),
            .adv_i      (adv[i]),
            .dyn_ceil_i (last_day),
            .wr_en_i    (wr_en[i]),
            .wr_val_i   (host_wdata),
            .val_o      (vals[i]),
            .carry_o    (carry[i])
        );
    end

    assign unused_carry = ^carry[NFIELD-1:IDX_YEAR];

    rtc_host_port u_host (
        .clk         (clk),
        .rst         (rst),
        .re_i        (host_re),
        .we_i        (host_we),
        .addr_i      (host_addr),
        .fields_i    (vals),
        .rdata_o     (host_rdata),
        .presc_clr_o (presc_clr)
    );

    assign sec_o   = vals[IDX_SEC];
    assign min_o   = vals[IDX_MIN];
    assign hour_o  = vals[IDX_HOUR];
    assign date_o  = vals[IDX_DATE];
    assign month_o = vals[IDX_MONTH];
    assign year_o  = vals[IDX_YEAR];
    assign wday_o  = vals[IDX_WDAY];
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_1hz,
    input logic [2:0] host_addr,
    input logic       host_we,
    input logic       host_re,
    input logic [7:0] host_rdata,
    input logic       presc_clr,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] date_o,
    input logic [7:0] wday_o
);
    logic day_end;
    assign day_end = tick_1hz && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23;

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        tick_1hz && !host_we && sec_o == 8'h59 |=> sec_o == 8'h00);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_1hz && !host_we |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(date_o));

    assert_hour_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        day_end && !host_we |=> hour_o == 8'h00);

    assert_wday_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !host_we && !day_end |=> $stable(wday_o));

    assert_read_live_R8: assert property (@(posedge clk) disable iff (rst)
        host_re && host_addr == 3'd0 |=> host_rdata == $past(sec_o));

    assert_presc_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        host_we && host_addr == 3'd0 |=> presc_clr);

    assert_presc_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !(host_we && host_addr == 3'd0) |=> !presc_clr);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_1hz   (tick_1hz),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_rdata (host_rdata),
    .presc_clr  (presc_clr),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o),
    .date_o     (date_o),
    .wday_o     (wday_o)
);

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [7:0] rdata, sec_o, min_o, hour_o, date_o, month_o, year_o, wday_o;
    logic       presc_clr;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;

    rtc_calendar dut (
        .clk(clk), .rst(rst), .tick_1hz(tick), .host_addr(addr), .host_wdata(wdata),
        .host_we(we), .host_re(re), .host_rdata(rdata), .presc_clr(presc_clr),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
        .month_o(month_o), .year_o(year_o), .wday_o(wday_o)
    );

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(int mon, int yr);
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        return 31;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model: integer fields
    int s, m, h, d, w, mo, y, rd, pc;
    int snap[8];

    always @(posedge clk) begin
        int os, om, oh, od, ow, omo, oy, lim;
        bit c1, c2, c3, c4, c5;
        if (rst) begin
            s = 0; m = 0; h = 0; d = 1; w = 0; mo = 1; y = 0; rd = 0; pc = 0;
            for (int k = 0; k < 8; k++) snap[k] = 0;
        end else begin
            os = s; om = m; oh = h; od = d; ow = w; omo = mo; oy = y;
            lim = mdays(omo, oy);
            c1 = tick && os >= 59;
            c2 = c1 && om >= 59;
            c3 = c2 && oh >= 23;
            c4 = c3 && od >= lim;
            c5 = c4 && omo >= 12;
            if (tick) s = c1 ? 0 : os + 1;
            if (c1) m = c2 ? 0 : om + 1;
            if (c2) h = c3 ? 0 : oh + 1;
            if (c3) begin
                d = c4 ? 1 : od + 1;
                w = (ow >= 6) ? 0 : ow + 1;
            end
            if (c4) mo = c5 ? 1 : omo + 1;
            if (c5) y = (oy >= 99) ? 0 : oy + 1;
            if (we) begin
                case (addr)
                    3'd0: s  = int'(wdata[7:4]) * 10 + int'(wdata[3:0]);
                    3'd1: m  = int'(wdata[7:4]) * 10 + int'(wdata[3:0]);
                    3'd2: h  = int'(wdata[7:4]) * 10 + int'(wdata[3:0]);
                    3'd3: d  = int'(wdata[7:4]) * 10 + int'(wdata[3:0]);
                    3'd4: mo = int'(wdata[7:4]) * 10 + int'(wdata[3:0]);
                    3'd5: y  = int'(wdata[7:4]) * 10 + int'(wdata[3:0]);
                    3'd6: w  = int'(wdata[7:4]) * 10 + int'(wdata[3:0]);
                    default: ;
                endcase
            end
            pc = (we && addr == 3'd0) ? 1 : 0;
            if (re) begin
                if (addr == 3'd0) begin
                    snap[1] = om; snap[2] = oh; snap[3] = od; snap[4] = omo;
                    snap[5] = oy; snap[6] = ow; snap[7] = 0;
                    rd = os;
                end else begin
                    rd = snap[addr];
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R2 seconds", sec_o, bcd(s));
            chk("R2 minutes", min_o, bcd(m));
            chk("R3 hours", hour_o, bcd(h));
            chk("R4 day of month", date_o, bcd(d));
            chk("R5 month", month_o, bcd(mo));
            chk("R5 year", year_o, bcd(y));
            chk("R6 weekday", wday_o, bcd(w));
            chk("R8 read data", rdata, bcd(rd));
            chk("R9 prescaler restart", {7'd0, presc_clr}, 8'(pc));
        end
    end

    task automatic cyc(bit t, bit wr, bit rq, int a, int v);
        tick = t; we = wr; re = rq; addr = 3'(a); wdata = bcd(v);
        @(negedge clk);
        tick = 1'b0; we = 1'b0; re = 1'b0;
    endtask

    task automatic load(int yy, int mm, int dd, int hh, int mi, int ss, int wd);
        cyc(0, 1, 0, 5, yy); cyc(0, 1, 0, 4, mm); cyc(0, 1, 0, 3, dd);
        cyc(0, 1, 0, 2, hh); cyc(0, 1, 0, 1, mi); cyc(0, 1, 0, 6, wd);
        cyc(0, 1, 0, 0, ss);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sec", sec_o, 8'h00); chk("R1 min", min_o, 8'h00);
        chk("R1 hour", hour_o, 8'h00); chk("R1 date", date_o, 8'h01);
        chk("R1 month", month_o, 8'h01); chk("R1 year", year_o, 8'h00);
        chk("R1 wday", wday_o, 8'h00); chk("R1 rdata", rdata, 8'h00);
        chk("R1 presc", {7'd0, presc_clr}, 8'h00);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);

        // R5 leap year 00 (2000): Feb 28 -> Feb 29, weekday 6 -> 0
        load(0, 2, 28, 23, 59, 59, 6);
        cyc(1, 0, 0, 0, 0);
        chk("R5 leap 2000 date", date_o, 8'h29);
        chk("R3 hour wrap", hour_o, 8'h00);
        chk("R6 weekday wrap", wday_o, 8'h00);

        // R4 non-leap February
        load(1, 2, 28, 23, 59, 59, 2);
        cyc(1, 0, 0, 0, 0);
        chk("R4 Feb non-leap date", date_o, 8'h01);
        chk("R4 Feb non-leap month", month_o, 8'h03);

        // R5 leap year 24 Feb 29 -> Mar 1
        load(24, 2, 29, 23, 59, 59, 3);
        cyc(1, 0, 0, 0, 0);
        chk("R5 leap Feb29 end", month_o, 8'h03);

        // R4 30-day month
        load(30, 4, 30, 23, 59, 59, 1);
        cyc(1, 0, 0, 0, 0);
        chk("R4 April end date", date_o, 8'h01);
        chk("R4 April end month", month_o, 8'h05);

        // R4 31-day month does not end on 30
        load(30, 7, 30, 23, 59, 59, 1);
        cyc(1, 0, 0, 0, 0);
        chk("R4 July 31", date_o, 8'h31);

        // R5 year end 99 -> 00
        load(99, 12, 31, 23, 59, 59, 4);
        cyc(1, 0, 0, 0, 0);
        chk("R5 year wrap", year_o, 8'h00);
        chk("R5 month wrap", month_o, 8'h01);
        chk("R5 date wrap", date_o, 8'h01);

        // R7 write to address 7 ignored
        load(10, 6, 15, 8, 20, 30, 2);
        cyc(0, 1, 0, 7, 55);
        chk("R7 addr7 sec", sec_o, 8'h30);
        chk("R7 addr7 min", min_o, 8'h20);
        chk("R7 addr7 wday", wday_o, 8'h02);

        // R8 snapshot across a carry
        load(10, 6, 15, 8, 10, 59, 2);
        cyc(1, 0, 1, 0, 0);
        chk("R8 live seconds", rdata, 8'h59);
        chk("R10 tick with read", min_o, 8'h11);
        cyc(0, 0, 1, 1, 0);
        chk("R8 snapshot minutes", rdata, 8'h10);
        cyc(0, 0, 1, 7, 0);
        chk("R8 address 7 read", rdata, 8'h00);

        // R7 / R9 write seconds during a tick
        load(10, 6, 15, 8, 10, 30, 2);
        cyc(1, 1, 0, 0, 45);
        chk("R7 write wins", sec_o, 8'h45);
        chk("R9 restart pulse", {7'd0, presc_clr}, 8'h01);
        cyc(0, 0, 0, 0, 0);
        chk("R9 pulse ends", {7'd0, presc_clr}, 8'h00);

        // R10 tick with a write elsewhere
        load(10, 6, 15, 8, 5, 59, 2);
        cyc(1, 1, 0, 2, 12);
        chk("R10 sec advanced", sec_o, 8'h00);
        chk("R10 min advanced", min_o, 8'h06);
        chk("R7 hour written", hour_o, 8'h12);

        // long run across midnight into March, random ticks and reads
        load(23, 2, 28, 22, 0, 0, 5);
        for (int n = 0; n < 90000; n++) begin
            int r;
            r = int'($urandom % 64);
            if (n % 4999 == 4998) cyc(r[0], 1, 0, 0, r % 60);
            else cyc(r < 40, 0, r[5], r % 8, 0);
        end
        chk("R4 long run month", month_o, 8'h03);

        cmp_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule